// File: doc/BRIEF.md
# Reed-Solomon Decoder Framing and Status Formatter

This block wraps a Reed-Solomon decoding core and handles everything around it except the algebra. After reset it holds its configuration: a 5-bit correction threshold, a status-byte enable and a latency-mode select. It then watches the data-enable line during the first block to learn how many data symbols (K) and parity symbols (R) each block carries. From then on it delays the received symbol stream by a latency computed from N = K + R, R and the selected mode. It frames the delayed stream and drives a data-ready marker, a one-clock end-of-block pulse, and per-block corrected and uncorrectable flags.

The decoding core posts one result per block: an error count and a failure flag. These results are queued in arrival order and consumed as each block starts to leave the delay line. During a corrected block the core supplies a per-symbol correction pattern, which is XORed onto the outgoing symbol. When status bytes are enabled, the first two parity positions of the output are replaced by a failure byte and a count byte. A correction-enable input, sampled with the first symbol of a block, lets that block pass untouched. A threshold above 20 turns the whole block into a plain delay.

Top module: `rs_frame_fmt`

## Requirements
- R1: While rst_ni is low all outputs are zero. The threshold, status enable and latency selects are captured on the first two clock edges after reset release and ignored afterwards.
- R2: The first rising edge of den_i after configuration opens the learning block. The count of high cycles gives K, the count of following low cycles gives R, and the next rise fixes N = K + R for all later blocks, including the learning block's own output framing.
- R3: A symbol sampled on edge e appears on sym_o after edge e+L. L is 2N+5R+33 with both selects low, 2N+2R+13 with lat_sel1_i high and lat_sel2_i low, and floor(3N/2)+floor(3R/2)+15 whenever lat_sel2_i is high.
- R4: rdy_o is high for the K data positions of an output block and low for its R parity positions and between blocks.
- R5: eob_o is high for exactly one clock, on the last (N-th) output position of each block.
- R6: A block is uncorrectable when its failure flag is set or twice its error count exceeds the threshold. Its symbols are output exactly as received, and unc_o is high for all of its output positions.
- R7: A block that is not uncorrectable and has a non-zero error count is corrected. corr_o is high for all of its output positions, and each symbol not replaced by a status byte leaves as received XOR fix_i.
- R8: With status enabled, output position K carries {uncorrectable, 7'b0} and position K+1 carries {3'b0, error count}.
- R9: If corr_en_i is low with a block's first symbol, that block passes unchanged: no correction, no status bytes, corr_o and unc_o low.
- R10: A threshold above 20 makes every block pass unchanged, with corr_o and unc_o low and no status bytes.
- R11: Core results (res_valid_i with res_cnt_i, res_fail_i) are applied to output blocks in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset, also phase one of configuration |
| sym_i | input | 8 | Received symbol |
| den_i | input | 1 | High for data symbols, low for parity symbols |
| corr_en_i | input | 1 | Correction enable, taken with the first symbol of a block |
| thr_i | input | 5 | Correction threshold, captured after reset |
| stat_en_i | input | 1 | Status-byte enable, captured after reset |
| lat_sel1_i | input | 1 | Latency select 1, captured after reset |
| lat_sel2_i | input | 1 | Latency select 2, captured after reset |
| res_valid_i | input | 1 | Core result strobe, one per block |
| res_cnt_i | input | 5 | Core error count for the block |
| res_fail_i | input | 1 | Core failure flag for the block |
| fix_i | input | 8 | Core correction pattern for the symbol being output |
| sym_o | output | 8 | Delayed, corrected or status symbol |
| rdy_o | output | 1 | Output symbol is a data symbol |
| eob_o | output | 1 | Last symbol of the output block |
| corr_o | output | 1 | Output block is being corrected |
| unc_o | output | 1 | Output block is uncorrectable |

## Verification
Contiguous streams of two or three blocks are run under each latency mode. An odd N shows whether the halving is floored on each term separately or on the sum, and the first output symbol is checked exactly one cycle after a parity position, which separates L from L±1. Blocks with zero, small and over-threshold error counts, and with the core failure flag, are mixed in one stream. A constant non-zero correction pattern makes it visible which blocks were modified and which status slots were overwritten. The bypass cases send blocks that would otherwise be corrected, so that any leak of a correction or status byte shows on sym_o.

// File: rtl/rs_fmt_pkg.sv
package rs_fmt_pkg;

  localparam int RES_CNT_W = 5;

  typedef enum logic [1:0] {
    LAT_STD  = 2'd0,
    LAT_FAST = 2'd1,
    LAT_HALF = 2'd2
  } lat_mode_e;

  typedef struct packed {
    logic                 fail;
    logic [RES_CNT_W-1:0] cnt;
  } blk_res_t;

  function automatic lat_mode_e pick_mode(input logic s1, input logic s2);
    if (s2) return LAT_HALF;
    if (s1) return LAT_FAST;
    return LAT_STD;
  endfunction

  // halves are floored per term
  function automatic logic [15:0] calc_lat(input lat_mode_e m, input logic [15:0] n,
                                           input logic [15:0] r);
    case (m)
      LAT_FAST: return (n << 1) + (r << 1) + 16'd13;
      LAT_HALF: return (((n << 1) + n) >> 1) + (((r << 1) + r) >> 1) + 16'd15;
      default:  return (n << 1) + (r << 2) + r + 16'd33;
    endcase
  endfunction

endpackage

// File: rtl/rs_geom_learn.sv
module rs_geom_learn
  import rs_fmt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             den_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             stat_en_i,
  input  logic             sel1_i,
  input  logic             sel2_i,
  output logic [THR_W-1:0] thr_o,
  output logic             stat_o,
  output lat_mode_e        mode_o,
  output logic [LEN_W-1:0] k_o,
  output logic [LEN_W-1:0] r_o,
  output logic             learned_o,
  output logic             start_o
);

  typedef enum logic [2:0] {G_CFG, G_IDLE, G_DATA, G_PAR, G_RUN} geom_st_e;

  geom_st_e         st_q;
  logic             cfg_cnt_q;
  logic             den_q;
  logic [LEN_W-1:0] k_cnt_q, r_cnt_q;
  logic             rise;

  assign rise      = den_i & ~den_q;
  assign start_o   = rise && (st_q != G_CFG);
  assign learned_o = (st_q == G_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= G_CFG;
      cfg_cnt_q <= 1'b0;
      den_q     <= 1'b0;
      k_cnt_q   <= '0;
      r_cnt_q   <= '0;
      k_o       <= '0;
      r_o       <= '0;
      thr_o     <= '0;
      stat_o    <= 1'b0;
      mode_o    <= LAT_STD;
    end else begin
      den_q <= den_i;
      case (st_q)
        G_CFG: begin
          thr_o     <= thr_i;
          stat_o    <= stat_en_i;
          mode_o    <= pick_mode(sel1_i, sel2_i);
          cfg_cnt_q <= 1'b1;
          if (cfg_cnt_q) st_q <= G_IDLE;
        end
        G_IDLE: if (rise) begin
          st_q    <= G_DATA;
          k_cnt_q <= LEN_W'(1);
        end
        G_DATA: if (den_i) k_cnt_q <= k_cnt_q + 1'b1;
        else begin
          st_q    <= G_PAR;
          r_cnt_q <= LEN_W'(1);
        end
        G_PAR: if (den_i) begin
          k_o  <= k_cnt_q;
          r_o  <= r_cnt_q;
          st_q <= G_RUN;
        end else r_cnt_q <= r_cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rs_delay_line.sv
module rs_delay_line #(
  parameter int W  = 10,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  wr_i,
  input  logic [AW-1:0] lag_i,
  output logic [W-1:0]  rd_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] rd_addr;

  assign rd_addr = wr_ptr_q - lag_i;
  assign rd_o    = mem[rd_addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) mem[wr_ptr_q] <= wr_i;

endmodule

// File: rtl/rs_res_fifo.sv
module rs_res_fifo
  import rs_fmt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  blk_res_t data_i,
  input  logic     pop_i,
  output blk_res_t head_o,
  output logic     empty_o
);

  localparam int PW = $clog2(DEPTH);

  blk_res_t    mem [DEPTH];
  logic [PW:0] wr_q, rd_q;
  logic        full;

  assign empty_o = (wr_q == rd_q);
  assign full    = (wr_q[PW-1:0] == rd_q[PW-1:0]) && (wr_q[PW] != rd_q[PW]);
  assign head_o  = mem[rd_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i && !full)    wr_q <= wr_q + 1'b1;
      if (pop_i && !empty_o)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) if (push_i && !full) mem[wr_q[PW-1:0]] <= data_i;

endmodule

// File: rtl/rs_frame_fmt.sv
module rs_frame_fmt
  import rs_fmt_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int THR_W     = 5,
  parameter int MAX_N     = 255,
  parameter int MAX_R     = 20,
  parameter int RES_DEPTH = 8,
  parameter int BYP_THR   = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SYM_W-1:0]     sym_i,
  input  logic                 den_i,
  input  logic                 corr_en_i,
  input  logic [THR_W-1:0]     thr_i,
  input  logic                 stat_en_i,
  input  logic                 lat_sel1_i,
  input  logic                 lat_sel2_i,
  input  logic                 res_valid_i,
  input  logic [RES_CNT_W-1:0] res_cnt_i,
  input  logic                 res_fail_i,
  input  logic [SYM_W-1:0]     fix_i,
  output logic [SYM_W-1:0]     sym_o,
  output logic                 rdy_o,
  output logic                 eob_o,
  output logic                 corr_o,
  output logic                 unc_o
);

  localparam int LEN_W   = $clog2(MAX_N + 1);
  localparam int MAX_LAT = 2 * MAX_N + 5 * MAX_R + 33;
  localparam int BUF_AW  = $clog2(MAX_LAT + 1);
  localparam int ENT_W   = SYM_W + 2;

  logic [THR_W-1:0]  thr_q;
  logic              stat_q;
  lat_mode_e         mode_q;
  logic [LEN_W-1:0]  k_q, r_q;
  logic              learned, start_in;

  rs_geom_learn #(.LEN_W(LEN_W), .THR_W(THR_W)) u_geom (
    .clk_i, .rst_ni, .den_i, .thr_i, .stat_en_i,
    .sel1_i(lat_sel1_i), .sel2_i(lat_sel2_i),
    .thr_o(thr_q), .stat_o(stat_q), .mode_o(mode_q),
    .k_o(k_q), .r_o(r_q), .learned_o(learned), .start_o(start_in)
  );

  logic [LEN_W:0]   n_len, n_last;
  logic [BUF_AW-1:0] lat, since_q;

  assign n_len  = {1'b0, k_q} + {1'b0, r_q};
  assign n_last = n_len - 1'b1;
  assign lat    = BUF_AW'(calc_lat(mode_q, 16'(n_len), 16'(r_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= '0;
    else if (since_q != '1)   since_q <= since_q + 1'b1;
  end

  logic [ENT_W-1:0] rd_ent;
  logic             rd_start, rd_byp;
  logic [SYM_W-1:0] rd_sym;

  rs_delay_line #(.W(ENT_W), .AW(BUF_AW)) u_dly (
    .clk_i, .rst_ni,
    .wr_i ({start_in, ~corr_en_i, sym_i}),
    .lag_i(lat),
    .rd_o (rd_ent)
  );

  assign {rd_start, rd_byp, rd_sym} = rd_ent;

  logic     sym_start, res_empty;
  blk_res_t res_head, head;

  assign sym_start = learned && (since_q >= lat) && rd_start;

  rs_res_fifo #(.DEPTH(RES_DEPTH)) u_res (
    .clk_i, .rst_ni,
    .push_i (res_valid_i),
    .data_i ('{fail: res_fail_i, cnt: res_cnt_i}),
    .pop_i  (sym_start),
    .head_o (res_head),
    .empty_o(res_empty)
  );

  assign head = res_empty ? '0 : res_head;

  // per-block state, taken at block start
  logic                 act_q, blk_byp_q, blk_unc_q, blk_corr_q;
  logic [RES_CNT_W-1:0] blk_cnt_q;
  logic [LEN_W-1:0]     pos_q;

  logic                 new_byp, new_unc, live;
  logic                 cur_byp, cur_unc, cur_corr;
  logic [RES_CNT_W-1:0] cur_cnt;
  logic [LEN_W-1:0]     pos;
  logic [LEN_W:0]       pos_nx;
  logic                 slot_a, slot_b;
  logic [SYM_W-1:0]     sym_nx;

  assign new_byp  = rd_byp || (thr_q > THR_W'(BYP_THR));
  assign new_unc  = head.fail || ((8'(head.cnt) << 1) > 8'(thr_q));
  assign cur_byp  = sym_start ? new_byp : blk_byp_q;
  assign cur_unc  = sym_start ? (new_unc && !new_byp) : blk_unc_q;
  assign cur_corr = sym_start ? (!new_unc && !new_byp && head.cnt != '0) : blk_corr_q;
  assign cur_cnt  = sym_start ? head.cnt : blk_cnt_q;
  assign live     = sym_start || act_q;
  assign pos      = sym_start ? '0 : pos_q;
  assign pos_nx   = {1'b0, pos} + 1'b1;
  assign slot_a   = live && stat_q && !cur_byp && (pos == k_q);
  assign slot_b   = live && stat_q && !cur_byp && (pos == k_q + 1'b1);

  always_comb begin
    if (slot_a)                sym_nx = SYM_W'({cur_unc, 7'b0});
    else if (slot_b)           sym_nx = SYM_W'(cur_cnt);
    else if (live && cur_corr) sym_nx = rd_sym ^ fix_i;
    else                       sym_nx = rd_sym;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      pos_q      <= '0;
      blk_byp_q  <= 1'b0;
      blk_unc_q  <= 1'b0;
      blk_corr_q <= 1'b0;
      blk_cnt_q  <= '0;
      sym_o      <= '0;
      rdy_o      <= 1'b0;
      eob_o      <= 1'b0;
      corr_o     <= 1'b0;
      unc_o      <= 1'b0;
    end else begin
      act_q      <= live && (pos_nx < n_len);
      if (live) pos_q <= pos_nx[LEN_W-1:0];
      blk_byp_q  <= cur_byp;
      blk_unc_q  <= cur_unc;
      blk_corr_q <= cur_corr;
      blk_cnt_q  <= cur_cnt;
      sym_o      <= sym_nx;
      rdy_o      <= live && (pos < k_q);
      eob_o      <= live && ({1'b0, pos} == n_last);
      corr_o     <= live && cur_corr;
      unc_o      <= live && cur_unc;
    end
  end

endmodule

// File: rtl/rs_frame_fmt_chk.sv
module rs_frame_fmt_chk #(
  parameter int THR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rdy_o,
  input logic             eob_o,
  input logic             corr_o,
  input logic             unc_o,
  input logic [THR_W-1:0] thr_q
);

  // R5
  eob_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_o |=> !eob_o);

  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && unc_o));

  // R6
  unc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unc_o) |-> rdy_o);

  // R7
  corr_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(corr_o) |-> $past(eob_o));

  // R10
  thr_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q > THR_W'(20)) |-> (!corr_o && !unc_o));

endmodule

bind rs_frame_fmt rs_frame_fmt_chk #(.THR_W(THR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .rdy_o (rdy_o),
  .eob_o (eob_o),
  .corr_o(corr_o),
  .unc_o (unc_o),
  .thr_q (thr_q)
);

// File: tb/tb_rs_frame_fmt.sv
`timescale 1ns/1ps
module tb_rs_frame_fmt;

  localparam int LOG = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = '0, fix = '0, sym_o;
  logic       den = 1'b0, corr_en = 1'b1, stat = 1'b0, sel1 = 1'b0, sel2 = 1'b0;
  logic [4:0] thr = '0, res_cnt = '0;
  logic       res_v = 1'b0, res_fail = 1'b0;
  logic       rdy_o, eob_o, corr_o, unc_o;

  int n_chk = 0, n_fail = 0, cyc;
  int st_cyc [4];
  int b_cnt [4];
  bit b_fail [4];
  bit b_en [4];

  logic [7:0] lg_sym [LOG];
  logic       lg_rdy [LOG], lg_eob [LOG], lg_corr [LOG], lg_unc [LOG];

  always #2 clk = ~clk;

  rs_frame_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .sym_i(din), .den_i(den), .corr_en_i(corr_en),
    .thr_i(thr), .stat_en_i(stat), .lat_sel1_i(sel1), .lat_sel2_i(sel2),
    .res_valid_i(res_v), .res_cnt_i(res_cnt), .res_fail_i(res_fail), .fix_i(fix),
    .sym_o(sym_o), .rdy_o(rdy_o), .eob_o(eob_o), .corr_o(corr_o), .unc_o(unc_o)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk)
    if (cyc < LOG) begin
      lg_sym[cyc]  = sym_o;
      lg_rdy[cyc]  = rdy_o;
      lg_eob[cyc]  = eob_o;
      lg_corr[cyc] = corr_o;
      lg_unc[cyc]  = unc_o;
    end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int pat(int b, int j);
    return (b * 53 + j * 7 + 3) & 8'hFF;
  endfunction

  function automatic int exp_lat(bit s1, bit s2, int n, int r);
    if (s2) return (3 * n) / 2 + (3 * r) / 2 + 15;
    if (s1) return 2 * n + 2 * r + 13;
    return 2 * n + 5 * r + 33;
  endfunction

  task automatic init_dut(input int p, input bit st, input bit s1, input bit s2);
    @(negedge clk);
    rst_n = 0; thr = 5'(p); stat = st; sel1 = s1; sel2 = s2;
    den = 0; din = 0; res_v = 0; fix = 0; corr_en = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_blocks(input int nb, input int k, input int r, input int lat);
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < k + r; j++) begin
        @(negedge clk);
        if (j == 0) st_cyc[b] = cyc + 1;
        din = 8'(pat(b, j)); den = (j < k); corr_en = b_en[b];
        res_v = (j == 2); res_cnt = 5'(b_cnt[b]); res_fail = b_fail[b];
      end
    @(negedge clk);
    den = 0; din = 0; res_v = 0; corr_en = 1;
    repeat (lat + 8) @(negedge clk);
  endtask

  task automatic verify(input int nb, input int k, input int r, input int lat,
                        input int p, input bit st, input int fx);
    int n = k + r;
    chk("R3 idle before first symbol", lg_rdy[st_cyc[0] + lat - 1], 0);
    for (int b = 0; b < nb; b++) begin
      bit byp = !b_en[b] || (p > 20);
      bit unc = !byp && (b_fail[b] || 2 * b_cnt[b] > p);
      bit cor = !byp && !unc && b_cnt[b] != 0;
      int nrdy = 0, neob = 0;
      for (int j = 0; j < n; j++) begin
        int idx = st_cyc[b] + lat + j;
        int es;
        string tg;
        if (st && !byp && j == k)          begin es = unc ? 8'h80 : 0; tg = "R8 status1"; end
        else if (st && !byp && j == k + 1) begin es = b_cnt[b];        tg = "R8 status2"; end
        else if (cor)                      begin es = pat(b, j) ^ fx;  tg = "R7 fixed"; end
        else begin
          es = pat(b, j);
          tg = (p > 20) ? "R10 raw" : !b_en[b] ? "R9 raw" : unc ? "R6 raw" : "R3 sym";
        end
        chk(tg, lg_sym[idx], es);
        chk("R4 rdy", lg_rdy[idx], (j < k) ? 1 : 0);
        chk("R5 eob", lg_eob[idx], (j == n - 1) ? 1 : 0);
        chk("R7/R11 corr", lg_corr[idx], cor);
        chk("R6/R11 unc", lg_unc[idx], unc);
        nrdy += lg_rdy[idx];
        neob += lg_eob[idx];
      end
      chk("R2 learned K", nrdy, k);
      chk("R5 one eob", neob, 1);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset sym", sym_o, 0);
    chk("R1 reset flags", {rdy_o, eob_o, corr_o, unc_o}, 0);
  endtask

  task automatic test_default();
    int lat = exp_lat(0, 0, 20, 4);
    init_dut(4, 0, 0, 0);
    thr = 5'd0;
    fix = 8'h80;
    b_cnt = '{0, 1, 3, 0}; b_fail = '{0, 0, 0, 0}; b_en = '{1, 1, 1, 1};
    run_blocks(3, 16, 4, lat);
    verify(3, 16, 4, lat, 4, 0, 8'h80);
    chk("R1 threshold latched", lg_corr[st_cyc[1] + lat], 1);
  endtask

  task automatic test_lat(input bit s1, input bit s2);
    int lat = exp_lat(s1, s2, 21, 5);
    init_dut(4, 0, s1, s2);
    b_cnt = '{0, 0, 0, 0}; b_fail = '{0, 0, 0, 0}; b_en = '{1, 1, 1, 1};
    run_blocks(2, 16, 5, lat);
    verify(2, 16, 5, lat, 4, 0, 0);
  endtask

  task automatic test_status();
    int lat = exp_lat(0, 0, 16, 4);
    init_dut(6, 1, 0, 0);
    fix = 8'h0F;
    b_cnt = '{2, 1, 4, 0}; b_fail = '{0, 1, 0, 0}; b_en = '{1, 1, 1, 1};
    run_blocks(3, 12, 4, lat);
    verify(3, 12, 4, lat, 6, 1, 8'h0F);
  endtask

  task automatic test_thr_bypass();
    int lat = exp_lat(0, 0, 16, 4);
    init_dut(21, 1, 0, 0);
    fix = 8'h55;
    b_cnt = '{1, 0, 0, 0}; b_fail = '{0, 1, 0, 0}; b_en = '{1, 1, 1, 1};
    run_blocks(2, 12, 4, lat);
    verify(2, 12, 4, lat, 21, 1, 8'h55);
  endtask

  task automatic test_corr_off();
    int lat = exp_lat(0, 0, 16, 4);
    init_dut(4, 1, 0, 0);
    fix = 8'h55;
    b_cnt = '{1, 1, 0, 0}; b_fail = '{0, 0, 0, 0}; b_en = '{0, 1, 1, 1};
    run_blocks(2, 12, 4, lat);
    verify(2, 12, 4, lat, 4, 1, 8'h55);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    test_reset();
    test_default();
    test_lat(1, 0);
    test_lat(1, 1);
    test_status();
    test_thr_bypass();
    test_corr_off();
    finish_run();
  end

endmodule